// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an external byte-wide asynchronous static RAM with 524,288 locations. The host hands it one request at a time (read or write, a 19-bit address and, for writes, a byte) over a valid/ready handshake. The block turns each request into a sequence of chip-enable, output-enable and write-enable levels on the memory pins. It waits a fixed number of clock cycles for each timing window, and for reads it returns the sampled byte with a one-cycle valid pulse.

Every strobe and the data-bus drive enable is registered, so the memory pins change only on clock edges. The address is put on the bus one full cycle before any strobe falls and held until the next request is taken. Access time, write pulse width and write-enable recovery are set by parameters counted in clock cycles.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low and right after it, chip enable, output enable and write enable are all high (inactive), the data bus is not driven, req_ready_o is high and rsp_valid_o is low.
- R2: A request is taken on a rising clock edge where req_valid_i and req_ready_o are both high. req_ready_o is high only when no access is in progress, and chip enable and write enable are high whenever req_ready_o is high.
- R3: In the cycle after acceptance, all strobes stay high while the new address is already on mem_addr_o. The address then stays unchanged for as long as chip enable is low.
- R4: A read (req_write_i = 0) holds chip enable and output enable low with write enable high for exactly ACC_CYC cycles. The bus is sampled at the clock edge that ends the last of them, and rsp_valid_o is high for exactly one cycle after that edge. With acceptance at edge a, the response is seen in the cycle after edge a+1+ACC_CYC, and req_ready_o is high again in that same cycle.
- R5: A write (req_write_i = 1) holds chip enable and write enable low together for exactly WP_CYC cycles, and output enable stays high the whole time.
- R6: The block drives mem_dq_io only while write enable is low. During that time it drives the byte that was taken with the request.
- R7: After a write, chip enable and write enable both stay high for REC_CYC recovery cycles. req_ready_o stays low during them, so the next access's strobes fall no earlier than REC_CYC+1 cycles after write enable rises. req_ready_o is high again in the cycle after edge a+1+WP_CYC+REC_CYC.
- R8: A read returns the byte most recently written to the same address.
- R9: A request shown while req_ready_o is low and withdrawn before req_ready_o returns has no effect: timing is unchanged and the memory contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Block can take a request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle pulse: rsp_rdata_o holds read data |
| rsp_rdata_o | output | 8 | Read byte |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_addr_o | output | 19 | Memory address bus |
| mem_dq_io | inout | 8 | Memory data bus, tri-state |

## Verification
The bench runs a chain of writes sent back to back with valid held high, a chain of reads, a write followed at once by a read of the same address, and requests separated by idle gaps. Chained traffic shows whether recovery blocks acceptance and whether the address setup cycle is kept. Gap traffic shows whether idle-time acceptance is correct. The behavioural memory drives a wrong byte until output enable has been low for ACC_CYC cycles, so a block that samples one cycle early returns wrong data. A request withdrawn while the block is busy, with a later read of its address, shows whether a request that was never taken can still reach the memory. The addresses include 0, the all-ones top address and alternating bit patterns.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RWAIT,
    ST_WPULSE,
    ST_REC
  } ctrl_state_e;
endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int MAX_VAL = 3,
  localparam int W = (MAX_VAL < 1) ? 1 : $clog2(MAX_VAL + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ACC_CYC = 3,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 2,
  localparam int MAX_C  = (ACC_CYC > WP_CYC) ? ((ACC_CYC > REC_CYC) ? ACC_CYC : REC_CYC)
                                             : ((WP_CYC > REC_CYC) ? WP_CYC : REC_CYC),
  localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_write_i,
  output logic ready_o,
  output logic accept_o,
  output logic capture_o,
  output logic ce_n_o,
  output logic oe_n_o,
  output logic we_n_o,
  output logic drive_o
);
  ctrl_state_e state_q, state_d;
  logic             is_wr_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  sram_wait_cnt #(.MAX_VAL(MAX_C - 1)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_SETUP;
      ST_SETUP: begin
        tmr_load = 1'b1;
        if (is_wr_q) begin
          state_d = ST_WPULSE;
          tmr_val = CNT_W'(WP_CYC - 1);
        end else begin
          state_d = ST_RWAIT;
          tmr_val = CNT_W'(ACC_CYC - 1);
        end
      end
      ST_RWAIT: if (tmr_zero) begin
        state_d   = ST_IDLE;
        capture_o = 1'b1;
      end
      ST_WPULSE: if (tmr_zero) begin
        state_d  = ST_REC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REC_CYC - 1);
      end
      ST_REC:   if (tmr_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) is_wr_q <= req_write_i;
    end
  end

  // pins registered from next state: glitch-free strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      drive_o <= 1'b0;
    end else begin
      ce_n_o  <= !(state_d == ST_RWAIT || state_d == ST_WPULSE);
      oe_n_o  <= !(state_d == ST_RWAIT);
      we_n_o  <= !(state_d == ST_WPULSE);
      drive_o <= (state_d == ST_WPULSE);
    end
  end

  a_r5_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> oe_n_o);
  a_r6_drive_only_we_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> !we_n_o);
  a_r2_idle_strobes_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ce_n_o && we_n_o));
  a_r7_rec_blocks_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> !ready_o);
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= capture_i;
      if (capture_i) rsp_rdata_o <= dq_i;
    end
  end

  a_r4_rsp_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int DW      = DATA_W,
  parameter int ACC_CYC = 3,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [AW-1:0] mem_addr_o,
  inout  wire  [DW-1:0] mem_dq_io
);
  logic          accept, capture, drive;
  logic [DW-1:0] wdata;

  sram_seq #(
    .ACC_CYC (ACC_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .ce_n_o      (mem_ce_no),
    .oe_n_o      (mem_oe_no),
    .we_n_o      (mem_we_no),
    .drive_o     (drive)
  );

  sram_datapath #(.ADDR_W(AW), .DATA_W(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .dq_i        (mem_dq_io),
    .addr_o      (mem_addr_o),
    .wdata_o     (wdata),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  assign mem_dq_io = drive ? wdata : {DW{1'bz}};

  a_r3_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> $stable(mem_addr_o));
  a_r3_setup_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> !$past(req_valid_i && req_ready_o));
endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ACC = 3;
  localparam int WP  = 2;
  localparam int REC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdat = '0;
  logic        ready, rsp_v, ce_n, oe_n, we_n;
  logic [7:0]  rdat;
  logic [18:0] maddr;
  wire  [7:0]  dq;
  logic        mdl_drv = 1'b0;
  logic [7:0]  mdl_val = '0;

  assign dq = mdl_drv ? mdl_val : 8'hzz;
  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl #(.ACC_CYC(ACC), .WP_CYC(WP), .REC_CYC(REC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_write_i(wr), .req_addr_i(addr), .req_wdata_i(wdat),
    .rsp_valid_o(rsp_v), .rsp_rdata_o(rdat), .mem_ce_no(ce_n),
    .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_addr_o(maddr), .mem_dq_io(dq)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0, running = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) cyc++;

  // reference model
  int         ready_at = 0;
  int         rsp_cyc[$];
  logic [7:0] rsp_dat[$];
  logic [7:0] ref_mem[int];

  always @(negedge clk) if (running) begin
    bit exp_rdy, exp_rsp;
    exp_rdy = (cyc >= ready_at);
    chk(ready == exp_rdy, "R2 R7 ready", int'(ready), int'(exp_rdy));
    exp_rsp = (rsp_cyc.size() > 0) && (rsp_cyc[0] == cyc);
    chk(rsp_v == exp_rsp, "R4 rsp_valid timing", int'(rsp_v), int'(exp_rsp));
    if (exp_rsp) begin
      chk(rdat == rsp_dat[0], "R8 read data", int'(rdat), int'(rsp_dat[0]));
      void'(rsp_cyc.pop_front());
      void'(rsp_dat.pop_front());
    end
    if (valid && exp_rdy) begin
      if (wr) begin
        ref_mem[int'(addr)] = wdat;
        ready_at = cyc + 2 + WP + REC;
      end else begin
        rsp_cyc.push_back(cyc + 2 + ACC);
        rsp_dat.push_back(ref_mem.exists(int'(addr)) ? ref_mem[int'(addr)] : 8'h00);
        ready_at = cyc + 2 + ACC;
      end
    end
  end

  // behavioural memory and pin-level checks
  logic [7:0]  mdl_mem[int];
  logic [18:0] addr_prev = '0;
  int rd_run = 0, wp_run = 0, rec_run = 0;
  bit after_wr = 0;

  always @(negedge clk) if (running) begin
    if (!ce_n) chk(maddr == addr_prev, "R3 address stable/setup", int'(maddr), int'(addr_prev));
    addr_prev = maddr;
    if (!ce_n && !oe_n) begin
      chk(we_n, "R4 we high during read", int'(we_n), 1);
      rd_run++;
    end else begin
      if (rd_run > 0) chk(rd_run == ACC, "R4 read strobe length", rd_run, ACC);
      rd_run = 0;
    end
    if (!ce_n && !we_n) begin
      chk(oe_n, "R5 oe high in write", int'(oe_n), 1);
      wp_run++;
      mdl_mem[int'(maddr)] = dq;
    end else begin
      if (wp_run > 0) begin
        chk(wp_run == WP, "R5 write pulse length", wp_run, WP);
        rec_run = 0;
        after_wr = 1;
      end
      wp_run = 0;
    end
    if (ce_n && we_n) rec_run++;
    else if (after_wr) begin
      chk(rec_run >= REC + 1, "R7 recovery before next strobe", rec_run, REC + 1);
      after_wr = 0;
    end
    mdl_drv = (rd_run > 0);
    if (rd_run >= ACC)
      mdl_val = mdl_mem.exists(int'(maddr)) ? mdl_mem[int'(maddr)] : 8'h00;
    else
      mdl_val = 8'hE7;
  end

  task automatic send(bit w, logic [18:0] a, logic [7:0] d);
    valid = 1'b1; wr = w; addr = a; wdat = d;
    do @(negedge clk); while (!ready);
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drain();
    valid = 1'b0;
    while (rsp_cyc.size() > 0 || cyc < ready_at + 1) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(ce_n && oe_n && we_n, "R1 strobes idle in reset", {ce_n, oe_n, we_n}, 3'b111);
    chk(ready, "R1 ready in reset", int'(ready), 1);
    chk(!rsp_v, "R1 no rsp in reset", int'(rsp_v), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && ready && !rsp_v, "R1 state after reset",
        {ce_n, oe_n, we_n, ready, rsp_v}, 5'b11110);
    running = 1;
    @(posedge clk); #1;
    // R5 R7: back-to-back write chain
    send(1, 19'h00000, 8'h3C);
    send(1, 19'h7FFFF, 8'hC3);
    send(1, 19'h2AAAA, 8'h55);
    send(1, 19'h55555, 8'hAA);
    // R8: back-to-back read chain
    send(0, 19'h00000, 8'h00);
    send(0, 19'h7FFFF, 8'h00);
    send(0, 19'h2AAAA, 8'h00);
    send(0, 19'h55555, 8'h00);
    drain();
    // write then read same address, no gap
    send(1, 19'h12345, 8'h9E);
    send(0, 19'h12345, 8'h00);
    drain();
    // R9: withdrawn request while busy
    send(1, 19'h00001, 8'h77);
    valid = 1'b1; wr = 1'b1; addr = 19'h2AAAA; wdat = 8'hEE;
    @(posedge clk); #1;
    valid = 1'b0;
    drain();
    send(0, 19'h2AAAA, 8'h00);  // expect 8'h55: R9
    send(0, 19'h00001, 8'h00);
    drain();
    // gap traffic
    send(1, 19'h00000, 8'h01);
    idle(3);
    send(0, 19'h00000, 8'h00);
    idle(1);
    send(0, 19'h7FFFF, 8'h00);
    drain();
    idle(4);
    running = 0;
    summary();
  end
endmodule